// File: doc/BRIEF.md
# Clock Divisor Control with Doze

This block holds one 16-bit control word that software reads and writes over a simple register port. The word selects a processor slow-down ratio, a fast RC postscaler divide and the two PLL divides. From the peripheral clock it produces a processor clock-enable strobe at the chosen slow-down ratio. It also turns the three divider selections into plain integer divide values for downstream clock logic.

Slow-down mode can end by itself. When the recover bit is set, an interrupt request clears the slow-down enable and the processor runs at the peripheral rate from the next cycle. When the ratio changes through a software write, the change waits for the end of the current strobe period, so no period is cut short.

Top module: `clkdiv_doze_ctrl`

## Requirements
- R1: After a synchronous active-low reset the register reads 0x3040, and `cpu_ce` is high on every cycle.
- R2: Bit 5 always reads 0 and ignores writes. Every other bit reads back the value last written.
- R3: With the slow-down enable (bit 11) at 1, `cpu_ce` is a one-cycle pulse once every 2^k cycles, where k is bits 14:12 (000 gives /1, 111 gives /128).
- R4: With bit 11 at 0, `cpu_ce` is high on every cycle, whatever bits 14:12 hold.
- R5: A write that changes the ratio or the enable takes effect only after the next `cpu_ce` pulse. The period that is running completes at its full length.
- R6: When the recover bit (bit 15) is 1, an `irq` cycle clears bit 11, and `cpu_ce` is high from the next cycle onward.
- R7: When bit 15 is 0, `irq` does not change bit 11 and does not disturb the `cpu_ce` period.
- R8: If `irq` clears bit 11 in the same cycle that a write sets it, bit 11 ends up at 0. The other written bits are stored.
- R9: `rc_div` equals 2^c for code c = 0..6 in bits 10:8, and code 7 gives 256.
- R10: `pll_pre_div` equals the value of bits 4:0 plus 2, so it ranges from 2 to 33.
- R11: `pll_post_div` decodes bits 7:6 as follows: 00 gives 2, 01 gives 4, 11 gives 8. The reserved code 10 is stored and reads back as written, and it gives 4.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Peripheral clock |
| rst_n | input | 1 | Synchronous active-low reset |
| wr_en | input | 1 | Write strobe for the control word |
| wr_data | input | 16 | Value to write |
| irq | input | 1 | Interrupt request, level sampled each cycle |
| rd_data | output | 16 | Current control word |
| cpu_ce | output | 1 | Processor clock-enable strobe |
| rc_div | output | 9 | Fast RC postscaler divide value |
| pll_pre_div | output | 6 | PLL input divide value |
| pll_post_div | output | 4 | PLL output divide value |

## Verification
A write is visible on `rd_data` and on the three decoded divide outputs one clock edge after the write strobe. The bench therefore samples these outputs on the falling edge that follows that edge. A ratio change shows up only as the gap between two `cpu_ce` pulses, so the bench first aligns to a pulse and then counts cycles to the next one. The no-shortening test counts how many cycles remain in the old period after a mid-period write. An interrupt clear is due one edge after `irq` is sampled, and the bench checks `cpu_ce` and bit 11 on exactly that falling edge.

// File: rtl/clkdiv_pkg.sv
// Shared widths, reset value and field layout of the clock divisor control word.
// Assumes a 16-bit word; the field order is software-visible.
package clkdiv_pkg;
    localparam int REG_W      = 16;
    localparam int DOZE_W     = 3;
    localparam int RC_W       = 3;
    localparam int POST_W     = 2;
    localparam int PRE_W      = 5;
    localparam int RC_OUT_W   = 9;
    localparam int PRE_OUT_W  = PRE_W + 1;
    localparam int POST_OUT_W = 4;
    localparam logic [REG_W-1:0] RESET_VAL = 16'h3040;
    localparam logic [REG_W-1:0] IMPL_MASK = 16'hFFDF;

    typedef struct packed {
        logic              recover;
        logic [DOZE_W-1:0] slow_sel;
        logic              slow_on;
        logic [RC_W-1:0]   rc_sel;
        logic [POST_W-1:0] post_sel;
        logic              spare;
        logic [PRE_W-1:0]  pre_sel;
    } ctl_word_t;
endpackage

// File: rtl/clkdiv_ctl_reg.sv
// Control word storage. It applies software writes with the unimplemented bit
// masked, and it clears the slow-down enable on an interrupt when recover is set.
// Assumes wr_en and irq are synchronous to clk.
module clkdiv_ctl_reg
    import clkdiv_pkg::*;
(
    input  logic             clk,
    input  logic             rst_n,
    input  logic             wr_en,
    input  logic [REG_W-1:0] wr_data,
    input  logic             irq,
    output ctl_word_t        ctl_q,
    output logic             irq_clr
);
    ctl_word_t ctl_d;

    // An interrupt clears slow-down only while recover is set in the stored word.
    assign irq_clr = irq && ctl_q.recover;

    // Next word: the write first, then the interrupt clear, which wins.
    always_comb begin
        ctl_d = ctl_q;
        if (wr_en) begin
            ctl_d = ctl_word_t'(wr_data & IMPL_MASK);
        end
        if (irq_clr) begin
            ctl_d.slow_on = 1'b0;
        end
    end

    // Word register with synchronous reset.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            ctl_q <= ctl_word_t'(RESET_VAL);
        end else begin
            ctl_q <= ctl_d;
        end
    end

    // R6/R8: an interrupt with recover set leaves slow-down disabled.
    p_irq_clears_r6: assert property (@(posedge clk) disable iff (!rst_n)
        (irq && ctl_q.recover) |=> !ctl_q.slow_on);
    // R7: an interrupt without recover leaves the enable alone.
    p_irq_ignored_r7: assert property (@(posedge clk) disable iff (!rst_n)
        (irq && !ctl_q.recover && !wr_en) |=> $stable(ctl_q.slow_on));
endmodule

// File: rtl/clkdiv_doze_gen.sv
// Processor clock-enable generator. It pulses once every 2^sh peripheral cycles.
// A new ratio is loaded only at a pulse boundary; force_one loads 1:1 at once.
// Assumes the select is stable or changes only through the register.
module clkdiv_doze_gen #(
    parameter int SEL_W = 3
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic [SEL_W-1:0] slow_sel,
    input  logic             slow_on,
    input  logic             force_one,
    output logic             ce
);
    localparam int CNT_W = (1 << SEL_W) - 1;

    logic [SEL_W-1:0] sh_q;
    logic [CNT_W-1:0] cnt_q;
    logic [CNT_W:0]   span;
    logic [CNT_W-1:0] limit;

    // Last count of the active period.
    always_comb begin
        span  = (CNT_W+1)'(1) << sh_q;
        limit = CNT_W'(span - 1'b1);
    end

    assign ce = (cnt_q == limit);

    // Period counter; the ratio is loaded at the boundary or forced to 1:1.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            sh_q  <= '0;
            cnt_q <= '0;
        end else if (force_one) begin
            sh_q  <= '0;
            cnt_q <= '0;
        end else if (ce) begin
            sh_q  <= slow_on ? slow_sel : '0;
            cnt_q <= '0;
        end else begin
            cnt_q <= cnt_q + 1'b1;
        end
    end

    // R3: the counter never passes the end of its period.
    p_cnt_bound_r3: assert property (@(posedge clk) disable iff (!rst_n)
        cnt_q <= limit);
    // R3: a pulse into a divided ratio lasts one cycle.
    p_single_pulse_r3: assert property (@(posedge clk) disable iff (!rst_n)
        (ce && slow_on && slow_sel != '0 && !force_one) |=> !ce);
    // R6: a forced return to 1:1 strobes on the next cycle.
    p_force_ce_r6: assert property (@(posedge clk) disable iff (!rst_n)
        force_one |=> ce);
endmodule

// File: rtl/clkdiv_decode.sv
// Turns the three divider selections into integer divide values.
// Pure combinational logic; the reserved output code maps to /4.
module clkdiv_decode
    import clkdiv_pkg::*;
(
    input  logic [RC_W-1:0]       rc_sel,
    input  logic [PRE_W-1:0]      pre_sel,
    input  logic [POST_W-1:0]     post_sel,
    output logic [RC_OUT_W-1:0]   rc_div,
    output logic [PRE_OUT_W-1:0]  pre_div,
    output logic [POST_OUT_W-1:0] post_div
);
    localparam logic [RC_W-1:0] RC_TOP = '1;

    // RC postscaler: powers of two, the top code jumps to 256.
    always_comb begin
        if (rc_sel == RC_TOP) begin
            rc_div = RC_OUT_W'(256);
        end else begin
            rc_div = RC_OUT_W'(1) << rc_sel;
        end
    end

    // PLL input divide: field plus two.
    assign pre_div = PRE_OUT_W'(pre_sel) + PRE_OUT_W'(2);

    // PLL output divide, with the reserved code treated as /4.
    always_comb begin
        case (post_sel)
            2'b00:   post_div = POST_OUT_W'(2);
            2'b11:   post_div = POST_OUT_W'(8);
            default: post_div = POST_OUT_W'(4);
        endcase
    end
endmodule

// File: rtl/clkdiv_doze_ctrl.sv
// Top level: control word, clock-enable generator and divide decoders.
// Assumes one clock domain (the peripheral clock) and a synchronous reset.
module clkdiv_doze_ctrl
    import clkdiv_pkg::*;
(
    input  logic                  clk,
    input  logic                  rst_n,
    input  logic                  wr_en,
    input  logic [REG_W-1:0]      wr_data,
    input  logic                  irq,
    output logic [REG_W-1:0]      rd_data,
    output logic                  cpu_ce,
    output logic [RC_OUT_W-1:0]   rc_div,
    output logic [PRE_OUT_W-1:0]  pll_pre_div,
    output logic [POST_OUT_W-1:0] pll_post_div
);
    ctl_word_t ctl;
    logic      irq_clr;

    clkdiv_ctl_reg u_reg (
        .clk     (clk),
        .rst_n   (rst_n),
        .wr_en   (wr_en),
        .wr_data (wr_data),
        .irq     (irq),
        .ctl_q   (ctl),
        .irq_clr (irq_clr)
    );

    clkdiv_doze_gen #(.SEL_W(DOZE_W)) u_gen (
        .clk       (clk),
        .rst_n     (rst_n),
        .slow_sel  (ctl.slow_sel),
        .slow_on   (ctl.slow_on),
        .force_one (irq_clr),
        .ce        (cpu_ce)
    );

    clkdiv_decode u_dec (
        .rc_sel   (ctl.rc_sel),
        .pre_sel  (ctl.pre_sel),
        .post_sel (ctl.post_sel),
        .rc_div   (rc_div),
        .pre_div  (pll_pre_div),
        .post_div (pll_post_div)
    );

    assign rd_data = ctl;

    // R2: the unimplemented bit never reads as 1 after a write.
    p_spare_zero_r2: assert property (@(posedge clk) disable iff (!rst_n)
        wr_en |=> !rd_data[5]);
    // R10: the PLL input divide stays within its range.
    p_pre_range_r10: assert property (@(posedge clk) disable iff (!rst_n)
        pll_pre_div >= 6'd2 && pll_pre_div <= 6'd33);
    // R11: the PLL output divide is always 2, 4 or 8.
    p_post_legal_r11: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot(pll_post_div) && pll_post_div != 4'd1);
endmodule

// File: tb/sim_clkdiv_doze_ctrl.sv
module sim_clkdiv_doze_ctrl;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        wr_en = 1'b0;
    logic [15:0] wr_data = '0;
    logic        irq = 1'b0;
    logic [15:0] rd_data;
    logic        cpu_ce;
    logic [8:0]  rc_div;
    logic [5:0]  pll_pre_div;
    logic [3:0]  pll_post_div;

    int n_chk = 0;
    int n_bad = 0;
    bit done = 1'b0;

    always #2 clk = ~clk;

    clkdiv_doze_ctrl u0 (
        .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_data(wr_data), .irq(irq),
        .rd_data(rd_data), .cpu_ce(cpu_ce), .rc_div(rc_div),
        .pll_pre_div(pll_pre_div), .pll_post_div(pll_post_div)
    );

    task automatic check(input string req, input int act, input int exp);
        n_chk++;
        if (act != exp) begin
            n_bad++;
            $display("FAIL %s: actual %0d (0x%0h) expected %0d (0x%0h)", req, act, act, exp, exp);
        end
    endtask

    // Called at a falling edge; the write lands on the next rising edge.
    task automatic wr(input logic [15:0] v);
        wr_en = 1'b1;
        wr_data = v;
        @(negedge clk);
        wr_en = 1'b0;
    endtask

    // Advance to a falling edge where cpu_ce is high.
    task automatic sync_ce();
        int g = 0;
        while (!cpu_ce && g < 400) begin
            @(negedge clk);
            g++;
        end
    endtask

    // From a pulse, count cycles up to the next pulse.
    task automatic gap(output int n);
        n = 0;
        do begin
            @(negedge clk);
            n++;
        end while (!cpu_ce && n < 400);
    endtask

    task automatic summary();
        if (!done) begin
            done = 1'b1;
            $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
            $finish;
        end
    endtask

    initial begin
        repeat (100000) @(posedge clk);
        n_chk++;
        n_bad++;
        $display("FAIL watchdog: actual timeout expected completion");
        summary();
    end

    initial begin
        int g;
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        // R1: reset value and a strobe on every cycle
        check("R1 reset word", rd_data, 16'h3040);
        for (int i = 0; i < 4; i++) begin
            check("R1 ce after reset", cpu_ce, 1);
            @(negedge clk);
        end

        // R9: sweep of the RC postscaler codes
        for (int c = 0; c < 8; c++) begin
            wr(16'h3040 | 16'(c << 8));
            check("R9 rc_div", rc_div, (c == 7) ? 256 : (1 << c));
        end
        // R10: sweep of the PLL input divider codes
        for (int p = 0; p < 32; p++) begin
            wr(16'h3040 & 16'hFFE0 | 16'(p));
            check("R10 pll_pre_div", pll_pre_div, p + 2);
        end
        // R11: PLL output codes, including the reserved one
        for (int q = 0; q < 4; q++) begin
            wr(16'h3000 | 16'(q << 6));
            check("R11 pll_post_div", pll_post_div, (q == 0) ? 2 : (q == 3) ? 8 : 4);
            check("R11 stored code", int'(rd_data[7:6]), q);
        end

        // R4: enable off with the largest ratio selected
        wr(16'h7000);
        for (int i = 0; i < 10; i++) begin
            check("R4 ce forced 1:1", cpu_ce, 1);
            @(negedge clk);
        end

        // R3: every ratio, two periods each
        for (int d = 0; d < 8; d++) begin
            wr(16'h0800 | 16'(d << 12));
            sync_ce();
            gap(g);
            check("R3 first period", g, 1 << d);
            gap(g);
            check("R3 second period", g, 1 << d);
        end

        // R5: switch /8 to /1 mid-period
        wr(16'h3800);
        sync_ce();
        gap(g);
        check("R5 settle /8", g, 8);
        @(negedge clk);
        wr(16'h0800);
        g = 0;
        while (!cpu_ce && g < 50) begin
            @(negedge clk);
            g++;
        end
        check("R5 old period completes", g, 6);
        for (int i = 0; i < 3; i++) begin
            @(negedge clk);
            check("R5 new ratio 1:1", cpu_ce, 1);
        end

        // R6: interrupt with recover set during a /128 period
        wr(16'hF800);
        sync_ce();
        gap(g);
        check("R6 settle /128", g, 128);
        repeat (3) @(negedge clk);
        irq = 1'b1;
        @(negedge clk);
        irq = 1'b0;
        check("R6 ce next cycle", cpu_ce, 1);
        check("R6 enable cleared", int'(rd_data[11]), 0);
        for (int i = 0; i < 3; i++) begin
            @(negedge clk);
            check("R6 stays 1:1", cpu_ce, 1);
        end

        // R7: interrupt without recover
        wr(16'h7800);
        sync_ce();
        gap(g);
        check("R7 settle /128", g, 128);
        repeat (2) @(negedge clk);
        irq = 1'b1;
        @(negedge clk);
        irq = 1'b0;
        check("R7 word unchanged", rd_data, 16'h7800);
        check("R7 period undisturbed", cpu_ce, 0);

        // R2: readback with the unimplemented bit
        wr(16'hFFFF);
        check("R2 all ones", rd_data, 16'hFFDF);
        wr(16'h0020);
        check("R2 bit5 only", rd_data, 16'h0000);
        wr(16'hA5A5);
        check("R2 pattern A", rd_data, 16'hA585);
        wr(16'h5A5A);
        check("R2 pattern B", rd_data, 16'h5A5A);

        // R8: simultaneous write of the enable and interrupt clear
        wr(16'h8000);
        wr_en = 1'b1;
        wr_data = 16'h8C00;
        irq = 1'b1;
        @(negedge clk);
        wr_en = 1'b0;
        irq = 1'b0;
        check("R8 clear wins", rd_data, 16'h8400);
        check("R8 ce 1:1", cpu_ce, 1);

        summary();
    end
endmodule